// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is a single-master I2C bus driver that software operates one bus event at a time. An 8-bit control word holds five self-clearing command bits. Setting exactly one of them starts one event: a start condition, a repeated start, a stop condition, the reception of one byte, or an acknowledge slot. A write to the transmit buffer starts a byte transmission. The bit stays readable as 1 while its event runs and drops back to 0 when the event finishes.

The block drives the bus through two active-high pull-low enables, one for SDA and one for SCL. It reads both lines back. Every bus phase lasts `clk_div` system clocks. A phase in which SCL is released only counts down while SCL reads high, so a slave that holds the clock low stretches that phase. When an event finishes, the block raises `irq` for one cycle and keeps the lines at their final levels until the next event. While an event runs, further command writes and buffer writes are dropped. A write that sets more than one command bit starts nothing and raises a collision flag instead.

Control word layout, with bit 7 as the MSB: bit 7 is an idle enable that has no effect in master mode. Bit 6 is the acknowledge status and is read-only. Bit 5 is the acknowledge value to send. Bit 4 starts an acknowledge slot, bit 3 receives a byte, bit 2 sends a stop, bit 1 sends a repeated start and bit 0 sends a start.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, `ctl_rdata` is 0x00, `sda_oe`, `scl_oe`, `busy`, `irq`, `rx_full` and `collision` are all 0.
- R2: The start command (bit 0) first pulls SDA low with SCL released for one phase, then pulls SCL low for one phase. Bit 0 reads 1 during the event and 0 afterwards. Both lines stay low while the block is idle.
- R3: The stop command (bit 2) holds both lines low for one phase, releases SCL for one phase, then releases SDA. Bit 2 reads 1 during the event and 0 afterwards.
- R4: The repeated-start command (bit 1) runs four phases with the line states (SDA low, SCL low) = (0,1), (0,0), (1,0), (1,1). Bit 1 reads 1 during the event and 0 afterwards.
- R5: A buffer write while idle sends 9 clock slots, each one phase with SCL low followed by one phase with SCL released. Slots 0 to 7 carry the data bits MSB first, with SDA pulled low for a 0. Slot 8 releases SDA. A final phase holds SCL low with SDA released. Bit 6 becomes the SDA level sampled at the end of slot 8: 1 means not acknowledged, 0 means acknowledged.
- R6: The receive command (bit 3) runs 8 slots with SDA released and a final phase with SCL low. The bits sampled at the end of each SCL-high phase, MSB first, appear on `rx_data`. `rx_full` is set, and a pulse on `rx_rd` clears it. Bit 3 reads 1 during the event and 0 afterwards.
- R7: The acknowledge command (bit 4) runs one slot that drives the acknowledge-value bit (bit 5), where 1 releases SDA (NACK) and 0 pulls it low (ACK). A final phase with SCL low and SDA released follows. A write that sets bit 4 uses the bit 5 value carried in the same write.
- R8: While `busy` is 1, command writes and buffer writes are ignored. The waveform in progress is unchanged and the bit that was written never reads as 1.
- R9: An idle command write with two or more of bits 4..0 set starts no event and sets `collision`. The command bits keep reading 0. The next accepted event clears `collision`.
- R10: `irq` is high for exactly the one cycle after the last phase of an event ends, in the same cycle that `busy` falls.
- R11: A phase with SCL released advances only on cycles in which `scl_in` reads high.
- R12: Bit 7 reads back what was written and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | System clocks per bus phase (0 acts as 1) |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word read value |
| buf_we | input | 1 | Transmit buffer write strobe (starts a byte when idle) |
| buf_wdata | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Clears the receive-full flag |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | A received byte is waiting |
| busy | output | 1 | An event is in progress |
| irq | output | 1 | One-cycle completion pulse |
| collision | output | 1 | Last command write set several command bits |
| sda_in | input | 1 | SDA line read-back |
| scl_in | input | 1 | SCL line read-back |
| sda_oe | output | 1 | Pull SDA low |
| scl_oe | output | 1 | Pull SCL low |

## Verification
The bench models each event as a queue of expected line states and compares them on every cycle. It steps a phase only when its own line model shows SCL high, so stretching shows up as a mismatch if the design counts through a held-low clock. A stop command and a buffer write are injected in the middle of a transmission. A design that queued or obeyed them would show a stray phase, a corrupted byte or a stop bit that reads 1. The bench also covers several corner cases:
- A transmission answered with NACK and one answered with ACK, which catch an inverted or stale acknowledge status.
- A double-bit command write, which exposes a design that acts on one of the bits instead of flagging the collision.
- Acknowledge slots sent with both values, which exercise the acknowledge value written in the same write as its command.
- Events run with a one-clock phase, which catch off-by-one errors in the phase counter.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    localparam int PH_W     = 5;
    localparam int SR_W     = 9;
    localparam int CMD_W    = 5;

    localparam int B_START  = 0;
    localparam int B_RSTART = 1;
    localparam int B_STOP   = 2;
    localparam int B_RECV   = 3;
    localparam int B_ACKSEQ = 4;
    localparam int B_ACKVAL = 5;
    localparam int B_ACKSTS = 6;
    localparam int B_IDLEEN = 7;

    localparam logic [PH_W-1:0] LAST_START  = 5'd1;
    localparam logic [PH_W-1:0] LAST_RSTART = 5'd3;
    localparam logic [PH_W-1:0] LAST_STOP   = 5'd2;
    localparam logic [PH_W-1:0] LAST_TX     = 5'd18;
    localparam logic [PH_W-1:0] LAST_RX     = 5'd16;
    localparam logic [PH_W-1:0] LAST_ACK    = 5'd2;

    typedef enum logic [2:0] {
        EV_IDLE, EV_START, EV_RSTART, EV_STOP, EV_SHIFT
    } ev_e;

    typedef enum logic [1:0] {
        K_BUS, K_TX, K_RX, K_ACK
    } kind_e;

    typedef struct packed {
        logic sda_low;
        logic scl_low;
    } lines_t;

    typedef struct packed {
        logic              go;
        logic              collide;
        ev_e               ev;
        kind_e             kind;
        logic [PH_W-1:0]   last;
        logic [SR_W-1:0]   sr;
        logic [CMD_W-1:0]  cmd;
    } launch_t;

    function automatic lines_t phase_lines(ev_e ev, logic [PH_W-1:0] ph,
                                           logic [PH_W-1:0] last, logic rel);
        lines_t l;
        l = '{sda_low: 1'b0, scl_low: 1'b0};
        case (ev)
            EV_START:  l = (ph == 0) ? '{1'b1, 1'b0} : '{1'b1, 1'b1};
            EV_RSTART: case (ph)
                           5'd0:    l = '{1'b0, 1'b1};
                           5'd1:    l = '{1'b0, 1'b0};
                           5'd2:    l = '{1'b1, 1'b0};
                           default: l = '{1'b1, 1'b1};
                       endcase
            EV_STOP:   case (ph)
                           5'd0:    l = '{1'b1, 1'b1};
                           5'd1:    l = '{1'b1, 1'b0};
                           default: l = '{1'b0, 1'b0};
                       endcase
            EV_SHIFT:  l = (ph == last) ? '{1'b0, 1'b1} : '{~rel, ~ph[0]};
            default:   l = '{1'b0, 1'b0};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase_end
);
    localparam logic [DIV_W:0] ONE = 1;

    logic [DIV_W-1:0] cnt_q;

    assign phase_end = run && (({1'b0, cnt_q} + ONE) >= {1'b0, div});

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= phase_end ? '0 : cnt_q + 1'b1;
        end
    end

    // R11: a stalled phase keeps its count
    a_r11_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
    import i2c_seq_pkg::*;
(
    input  logic       busy,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       buf_we,
    input  logic [7:0] buf_wdata,
    output launch_t    launch
);
    logic [CMD_W-1:0] req;

    assign req = ctl_we ? ctl_wdata[CMD_W-1:0] : '0;

    always_comb begin
        launch = '{go: 1'b0, collide: 1'b0, ev: EV_IDLE, kind: K_BUS,
                   last: '0, sr: '1, cmd: '0};
        if (!busy) begin
            if ($countones(req) > 1) begin
                launch.collide = 1'b1;
            end else if (req != '0) begin
                launch.go  = 1'b1;
                launch.cmd = req;
                if (req[B_START]) begin
                    launch.ev = EV_START;  launch.last = LAST_START;
                end else if (req[B_RSTART]) begin
                    launch.ev = EV_RSTART; launch.last = LAST_RSTART;
                end else if (req[B_STOP]) begin
                    launch.ev = EV_STOP;   launch.last = LAST_STOP;
                end else if (req[B_RECV]) begin
                    launch.ev = EV_SHIFT;  launch.last = LAST_RX;
                    launch.kind = K_RX;
                end else begin
                    launch.ev = EV_SHIFT;  launch.last = LAST_ACK;
                    launch.kind = K_ACK;
                    launch.sr = {ctl_wdata[B_ACKVAL], 8'hFF};
                end
            end else if (buf_we) begin
                launch.go   = 1'b1;
                launch.ev   = EV_SHIFT;
                launch.kind = K_TX;
                launch.last = LAST_TX;
                launch.sr   = {buf_wdata, 1'b1};
            end
        end
    end

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rdata,
    input  logic             buf_we,
    input  logic [7:0]       buf_wdata,
    input  logic             rx_rd,
    output logic [7:0]       rx_data,
    output logic             rx_full,
    output logic             busy,
    output logic             irq,
    output logic             collision,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             sda_oe,
    output logic             scl_oe
);
    ev_e              ev_q;
    kind_e            kind_q;
    logic [PH_W-1:0]  ph_q, last_q;
    logic [SR_W-1:0]  sr_q;
    logic [CMD_W-1:0] cmd_q;
    logic             idle_en_q, ack_val_q, ack_sts_q;
    lines_t           hold_q, cur;
    logic [7:0]       rx_q;
    logic             rx_full_q, coll_q, irq_q;
    launch_t          launch;
    logic             high_phase, phase_end, run;
    logic             unused_ro_bit;

    assign unused_ro_bit = ctl_wdata[B_ACKSTS];

    assign busy       = (ev_q != EV_IDLE);
    assign cur        = phase_lines(ev_q, ph_q, last_q, sr_q[SR_W-1]);
    assign high_phase = busy && !cur.scl_low;
    assign run        = busy && (!high_phase || scl_in);
    assign sda_oe     = busy ? cur.sda_low : hold_q.sda_low;
    assign scl_oe     = busy ? cur.scl_low : hold_q.scl_low;

    i2c_cmd_decode u_decode (
        .busy      (busy),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .buf_we    (buf_we),
        .buf_wdata (buf_wdata),
        .launch    (launch)
    );

    i2c_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (launch.go),
        .run       (run),
        .div       (clk_div),
        .phase_end (phase_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q      <= EV_IDLE;
            kind_q    <= K_BUS;
            ph_q      <= '0;
            last_q    <= '0;
            sr_q      <= '1;
            cmd_q     <= '0;
            idle_en_q <= 1'b0;
            ack_val_q <= 1'b0;
            ack_sts_q <= 1'b0;
            hold_q    <= '{1'b0, 1'b0};
            rx_q      <= '0;
            rx_full_q <= 1'b0;
            coll_q    <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (ctl_we) begin
                idle_en_q <= ctl_wdata[B_IDLEEN];
                ack_val_q <= ctl_wdata[B_ACKVAL];
            end
            if (rx_rd) rx_full_q <= 1'b0;
            if (launch.collide) coll_q <= 1'b1;
            if (launch.go) begin
                coll_q <= 1'b0;
                ev_q   <= launch.ev;
                kind_q <= launch.kind;
                ph_q   <= '0;
                last_q <= launch.last;
                sr_q   <= launch.sr;
                cmd_q  <= launch.cmd;
            end else if (phase_end) begin
                if (ph_q == last_q) begin
                    ev_q   <= EV_IDLE;
                    hold_q <= cur;
                    cmd_q  <= '0;
                    irq_q  <= 1'b1;
                    if (kind_q == K_TX) ack_sts_q <= sr_q[0];
                    if (kind_q == K_RX) begin
                        rx_q      <= sr_q[7:0];
                        rx_full_q <= 1'b1;
                    end
                end else begin
                    ph_q <= ph_q + 5'd1;
                    if (ev_q == EV_SHIFT && ph_q[0])
                        sr_q <= {sr_q[SR_W-2:0], sda_in};
                end
            end
        end
    end

    assign ctl_rdata = {idle_en_q, ack_sts_q, ack_val_q, cmd_q};
    assign rx_data   = rx_q;
    assign rx_full   = rx_full_q;
    assign collision = coll_q;
    assign irq       = irq_q;

    // R10: completion pulse lasts one cycle
    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    // R8: a running event is never replaced by another
    a_r8_no_replace: assert property (@(posedge clk) disable iff (rst)
        busy |=> (ev_q == $past(ev_q) || ev_q == EV_IDLE));
    // R9: collisions are only flagged while idle
    a_r9_coll_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(collision) |-> !busy);
    // R9: at most one command bit is live
    a_r9_one_cmd: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_q));
    // R11: a held-low SCL stalls the phase
    a_r11_stall: assert property (@(posedge clk) disable iff (rst)
        (high_phase && !scl_in) |=> (busy && $stable(ph_q)));
    // R2: lines hold their levels while idle
    a_r2_lines_held: assert property (@(posedge clk) disable iff (rst)
        (!busy && !launch.go) |=> ($stable(sda_oe) && $stable(scl_oe)));

endmodule

// File: tb/i2c_cmd_master_tb_top.sv
module i2c_cmd_master_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] clk_div = 8'd3;
    logic       ctl_we = 1'b0, buf_we = 1'b0, rx_rd = 1'b0;
    logic [7:0] ctl_wdata = '0, buf_wdata = '0;
    logic [7:0] ctl_rdata, rx_data;
    logic       rx_full, busy, irq, collision, sda_oe, scl_oe;
    logic       slave_sda = 1'b1, hold_low = 1'b0;
    logic       sda_in, scl_in;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic [1:0] lv[$];

    assign sda_in = ~sda_oe & slave_sda;
    assign scl_in = ~scl_oe & ~hold_low;

    always #(CLK_P/2) clk = ~clk;

    i2c_cmd_master #(.DIV_W(8)) dut_i (
        .clk(clk), .rst(rst), .clk_div(clk_div),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_full(rx_full), .busy(busy), .irq(irq),
        .collision(collision), .sda_in(sda_in), .scl_in(scl_in),
        .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit sda_low, input bit scl_low);
        lv.push_back({sda_low, scl_low});
    endtask

    task automatic push_slots(input logic [8:0] drive, input int n);
        for (int j = 0; j < n; j++) begin
            push(~drive[8-j], 1'b1);
            push(~drive[8-j], 1'b0);
        end
        push(1'b0, 1'b1);
    endtask

    // mode: 0 bus event, 1 transmit, 2 receive
    task automatic run_cmd(input string req, input logic [7:0] wd, input bit use_buf,
                           input int bitidx, input int mode, input logic [7:0] sbyte,
                           input logic sack, input int stretch, input int inject);
        int i = 0, c = 0, cyc = 0, sl = stretch, slot;
        logic [1:0] lastv;
        @(negedge clk);
        if (use_buf) begin buf_we = 1'b1; buf_wdata = wd; end
        else begin ctl_we = 1'b1; ctl_wdata = wd; end
        @(negedge clk);
        ctl_we = 1'b0; buf_we = 1'b0;
        while (i < lv.size()) begin
            slot = i / 2;
            slave_sda = 1'b1;
            if (mode == 1 && slot == 8 && i < 18) slave_sda = sack;
            if (mode == 2 && slot < 8) slave_sda = sbyte[7-slot];
            hold_low = (sl > 0 && lv[i][0] == 1'b0);
            if (hold_low) sl--;
            if (cyc == inject) begin
                ctl_we = 1'b1; ctl_wdata = 8'h04; buf_we = 1'b1; buf_wdata = 8'hFF;
            end
            #1;
            chk({busy, sda_oe, scl_oe} == {1'b1, lv[i]}, req, "busy/sda/scl",
                {busy, sda_oe, scl_oe}, {1'b1, lv[i]});
            if (bitidx >= 0) chk(ctl_rdata[bitidx], req, "command bit live", ctl_rdata, 1);
            if (!(lv[i][0] == 1'b0 && !scl_in)) begin
                c++;
                if (c == int'(clk_div)) begin i++; c = 0; end
            end
            @(negedge clk);
            ctl_we = 1'b0; buf_we = 1'b0; cyc++;
        end
        lastv = lv[lv.size()-1];
        slave_sda = 1'b1; hold_low = 1'b0;
        #1;
        chk(!busy && irq && {sda_oe, scl_oe} == lastv, "R10", "end of event",
            {busy, irq, sda_oe, scl_oe}, {2'b01, lastv});
        if (bitidx >= 0) chk(!ctl_rdata[bitidx], req, "command bit cleared", ctl_rdata, 0);
        @(negedge clk); #1;
        chk(!irq, "R10", "irq one cycle", irq, 0);
        lv.delete();
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk(ctl_rdata == 8'h00, "R1", "ctl_rdata", ctl_rdata, 0);
        chk({sda_oe, scl_oe, busy, irq, rx_full, collision} == 6'b0, "R1", "outputs",
            {sda_oe, scl_oe, busy, irq, rx_full, collision}, 0);

        // R12: idle enable bit has no effect
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h80;
        @(negedge clk); ctl_we = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(!busy && !sda_oe && !scl_oe && ctl_rdata == 8'h80, "R12", "no activity",
                {busy, sda_oe, scl_oe, ctl_rdata}, 8'h80);
            @(negedge clk);
        end

        // R9: collision
        ctl_we = 1'b1; ctl_wdata = 8'h03;
        @(negedge clk); ctl_we = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(collision && !busy && ctl_rdata[4:0] == 5'd0 && !sda_oe && !scl_oe,
                "R9", "collision", {collision, busy, ctl_rdata[4:0]}, 7'h40);
            @(negedge clk);
        end

        // R2: start
        push(1, 0); push(1, 1);
        run_cmd("R2", 8'h01, 0, 0, 0, 0, 0, 0, -1);
        chk(!collision, "R9", "collision cleared", collision, 0);

        // R5 + R8: transmit with injected writes
        push_slots({8'hA5, 1'b1}, 9);
        run_cmd("R8", 8'hA5, 1, -1, 1, 0, 1'b0, 0, 10);
        chk(ctl_rdata[6] == 1'b0, "R5", "ack received", ctl_rdata[6], 0);
        chk(ctl_rdata[2] == 1'b0, "R8", "stop not accepted", ctl_rdata[2], 0);

        // R5: transmit answered by NACK
        push_slots({8'h3C, 1'b1}, 9);
        run_cmd("R5", 8'h3C, 1, -1, 1, 0, 1'b1, 0, -1);
        chk(ctl_rdata[6] == 1'b1, "R5", "nack status", ctl_rdata[6], 1);

        // R4 + R11: repeated start with stretched clock
        push(0, 1); push(0, 0); push(1, 0); push(1, 1);
        run_cmd("R4", 8'h02, 0, 1, 0, 0, 0, 4, -1);

        // R6: receive
        push_slots(9'h1FF, 8);
        run_cmd("R6", 8'h08, 0, 3, 2, 8'hC9, 1'b1, 0, -1);
        chk(rx_data == 8'hC9 && rx_full, "R6", "received byte", {rx_full, rx_data}, 9'h1C9);
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0; #1;
        chk(!rx_full, "R6", "rx_full cleared", rx_full, 0);

        // R7: acknowledge slot sending NACK, then ACK
        push_slots(9'h1FF, 1);
        run_cmd("R7", 8'h30, 0, 4, 0, 0, 0, 0, -1);
        chk(ctl_rdata[5], "R7", "ack value bit", ctl_rdata, 8'h20);
        push_slots(9'h0FF, 1);
        run_cmd("R7", 8'h10, 0, 4, 0, 0, 0, 0, -1);

        // R3: stop
        push(1, 1); push(1, 0); push(0, 0);
        run_cmd("R3", 8'h04, 0, 2, 0, 0, 0, 0, -1);

        // R2/R3 with one-clock phases
        clk_div = 8'd1;
        push(1, 0); push(1, 1);
        run_cmd("R2", 8'h01, 0, 0, 0, 0, 0, 0, -1);
        push(1, 1); push(1, 0); push(0, 0);
        run_cmd("R3", 8'h04, 0, 2, 0, 0, 0, 0, -1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule